// File: doc/BRIEF.md
# Linked Context Breakpoint Checker

This block decides whether the breakpoint slot that a data watchpoint links to currently allows the watchpoint to fire. A watchpoint supplies a 4-bit link number. The checker then looks at the slot that number selects. The slot must be among the context-aware slots. It must be enabled and programmed as a linked context-identifier comparator. The core must be running at exception level 0 or 1. The running context identifier must equal the value the slot holds. If all of these hold, the single output bit is high.

The number of implemented slots and the number of context-aware slots both arrive as "count minus one" fields. The context-aware slots always sit at the top of the slot range. Any link outside that top group gives no match, as does any type code other than the linked context type. The decision is combinational. A parameter selects an optional output flop that adds one cycle of latency.

Top module: `lcb_link_checker`

## Requirements
- R1: When `link_num` is greater than `bkpt_cnt_m1`, `match_o` is 0.
- R2: When `link_num` is less than `bkpt_cnt_m1 - ctx_cnt_m1`, `match_o` is 0. Both window ends are inclusive, so the slots from `bkpt_cnt_m1 - ctx_cnt_m1` up to `bkpt_cnt_m1` can match.
- R3: When bit 0 (enable) of `bkpt_ctrl` is 0, `match_o` is 0.
- R4: The slot type is `bkpt_ctrl[23:20]`. Only the code 3 (linked context-identifier compare) can give a match. Every other code gives no match, including 5, 9, 11 and all reserved codes.
- R5: When `cur_el` is 2 or 3, `match_o` is 0.
- R6: A match needs all 32 bits of `cur_ctxid` to equal `bkpt_value[31:0]`, with no masking. `bkpt_value[63:32]` has no effect.
- R7: `ctx_cnt_m1` never exceeds `bkpt_cnt_m1`. Under that rule, setting `ctx_cnt_m1` equal to `bkpt_cnt_m1` makes every implemented slot linkable.
- R8: With `REGISTER_OUT`=1, `match_o` is the decision for the inputs sampled at the previous rising clock edge, and it is 0 while `rst_n` is low (asynchronous, active low). With `REGISTER_OUT`=0, `match_o` follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output flop and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_num | input | 4 | Slot number the watchpoint links to |
| bkpt_cnt_m1 | input | 4 | Number of implemented slots minus one |
| ctx_cnt_m1 | input | 4 | Number of context-aware slots minus one |
| bkpt_ctrl | input | 32 | Control word of the linked slot (enable in bit 0, type in bits 23:20) |
| bkpt_value | input | 64 | Value word of the linked slot |
| cur_ctxid | input | 32 | Running context identifier |
| cur_el | input | 2 | Current exception level |
| match_o | output | 1 | Linked slot passes its context check |

## Verification
The bench builds two copies of the block side by side with the default widths: one with `REGISTER_OUT`=0 and one with `REGISTER_OUT`=1. Both copies receive the same stimulus, so every vector checks the same-cycle decision and the one-cycle-delayed decision.

The 4-bit link, count and context-count fields are swept over every legal combination, which exercises every possible window. The type code is also swept over all 16 codes, crossed with both enable values and all four exception levels.

Single-bit flips across the whole context identifier, together with varied upper value bits, exercise the compare width. The flips show that every one of the 32 bits takes part in the compare, and the upper-bit variations show that the top half of the value word has no effect.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
    localparam int unsigned LINK_W   = 4;
    localparam int unsigned TYPE_LSB = 20;
    localparam int unsigned TYPE_W   = 4;
    localparam int unsigned EN_BIT   = 0;
    localparam int unsigned MAX_EL   = 1;

    typedef enum logic [TYPE_W-1:0] {
        BT_CTX_LINKED      = 4'd3,
        BT_MISMATCH_LINKED = 4'd5,
        BT_VMID_LINKED     = 4'd9,
        BT_CTX_VMID_LINKED = 4'd11
    } bkpt_type_e;
endpackage

// File: rtl/lcb_slot_window.sv
module lcb_slot_window #(
    parameter int unsigned LW = 4
) (
    input  logic [LW-1:0] link_num,
    input  logic [LW-1:0] cnt_m1,
    input  logic [LW-1:0] ctx_m1,
    output logic          in_window
);
    localparam int unsigned EW = LW + 1;

    logic [EW-1:0] lower_ext;
    logic          cfg_ok;

    always_comb begin
        lower_ext = {1'b0, cnt_m1} - {1'b0, ctx_m1};
        cfg_ok    = ~lower_ext[EW-1];
        in_window = cfg_ok && (link_num <= cnt_m1) && ({1'b0, link_num} >= lower_ext);
    end
endmodule

// File: rtl/lcb_type_gate.sv
module lcb_type_gate
    import lcb_pkg::*;
#(
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned EL_W   = 2
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [EL_W-1:0]   el,
    output logic              armed
);
    logic [TYPE_W-1:0] type_code;
    logic              type_ok;
    logic              el_ok;
    logic              unused_ctrl;

    assign type_code   = ctrl[TYPE_LSB +: TYPE_W];
    assign unused_ctrl = ^{ctrl[CTRL_W-1:TYPE_LSB+TYPE_W], ctrl[TYPE_LSB-1:EN_BIT+1]};

    always_comb begin
        unique case (type_code)
            BT_CTX_LINKED:      type_ok = 1'b1;
            BT_MISMATCH_LINKED: type_ok = 1'b0;
            BT_VMID_LINKED:     type_ok = 1'b0;
            BT_CTX_VMID_LINKED: type_ok = 1'b0;
            default:            type_ok = 1'b0;
        endcase
        el_ok = (el <= EL_W'(MAX_EL));
        armed = ctrl[EN_BIT] && type_ok && el_ok;
    end
endmodule

// File: rtl/lcb_ctx_compare.sv
module lcb_ctx_compare #(
    parameter int unsigned ID_W = 32
) (
    input  logic [ID_W-1:0] cur_id,
    input  logic [ID_W-1:0] slot_id,
    output logic            equal
);
    assign equal = (cur_id == slot_id);
endmodule

// File: rtl/lcb_link_checker.sv
module lcb_link_checker
    import lcb_pkg::*;
#(
    parameter int unsigned CTRL_W       = 32,
    parameter int unsigned VAL_W        = 64,
    parameter int unsigned ID_W         = 32,
    parameter int unsigned EL_W         = 2,
    parameter bit          REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] link_num,
    input  logic [LINK_W-1:0] bkpt_cnt_m1,
    input  logic [LINK_W-1:0] ctx_cnt_m1,
    input  logic [CTRL_W-1:0] bkpt_ctrl,
    input  logic [VAL_W-1:0]  bkpt_value,
    input  logic [ID_W-1:0]   cur_ctxid,
    input  logic [EL_W-1:0]   cur_el,
    output logic              match_o
);
    logic in_window;
    logic armed;
    logic id_equal;
    logic match_c;
    logic unused_val_hi;

    assign unused_val_hi = ^bkpt_value[VAL_W-1:ID_W];

    lcb_slot_window #(.LW(LINK_W)) u_window (
        .link_num  (link_num),
        .cnt_m1    (bkpt_cnt_m1),
        .ctx_m1    (ctx_cnt_m1),
        .in_window (in_window)
    );

    lcb_type_gate #(.CTRL_W(CTRL_W), .EL_W(EL_W)) u_type (
        .ctrl  (bkpt_ctrl),
        .el    (cur_el),
        .armed (armed)
    );

    lcb_ctx_compare #(.ID_W(ID_W)) u_cmp (
        .cur_id  (cur_ctxid),
        .slot_id (bkpt_value[ID_W-1:0]),
        .equal   (id_equal)
    );

    assign match_c = in_window && armed && id_equal;

    generate
        if (REGISTER_OUT) begin : g_reg
            logic match_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) match_q <= 1'b0;
                else        match_q <= match_c;
            end
            assign match_o = match_q;

            a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (match_o == $past(match_c)));
        end else begin : g_comb
            assign match_o = match_c;
        end
    endgenerate

    a_r1_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> (link_num <= bkpt_cnt_m1));
    a_r2_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> ({1'b0, link_num} + {1'b0, ctx_cnt_m1} >= {1'b0, bkpt_cnt_m1}));
    a_r3_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> bkpt_ctrl[EN_BIT]);
    a_r4_ctx_type: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> (bkpt_ctrl[TYPE_LSB +: TYPE_W] == 4'd3));
    a_r5_low_el: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> (cur_el < EL_W'(2)));
    a_r6_full_id: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |-> (cur_ctxid == bkpt_value[ID_W-1:0]));
    a_r7_cfg_order: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_cnt_m1 <= bkpt_cnt_m1);
endmodule

// File: tb/lcb_link_checker_tb.sv
module lcb_link_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  link_num = '0;
    logic [3:0]  bkpt_cnt_m1 = '0;
    logic [3:0]  ctx_cnt_m1 = '0;
    logic [31:0] bkpt_ctrl = '0;
    logic [63:0] bkpt_value = '0;
    logic [31:0] cur_ctxid = '0;
    logic [1:0]  cur_el = '0;
    logic        match_reg;
    logic        match_comb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lcb_link_checker #(.REGISTER_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_num(link_num), .bkpt_cnt_m1(bkpt_cnt_m1),
        .ctx_cnt_m1(ctx_cnt_m1), .bkpt_ctrl(bkpt_ctrl), .bkpt_value(bkpt_value),
        .cur_ctxid(cur_ctxid), .cur_el(cur_el), .match_o(match_reg)
    );

    lcb_link_checker #(.REGISTER_OUT(1'b0)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .link_num(link_num), .bkpt_cnt_m1(bkpt_cnt_m1),
        .ctx_cnt_m1(ctx_cnt_m1), .bkpt_ctrl(bkpt_ctrl), .bkpt_value(bkpt_value),
        .cur_ctxid(cur_ctxid), .cur_el(cur_el), .match_o(match_comb)
    );

    function automatic bit model(int lk, int cnt, int ctx, logic [31:0] ctl,
                                 logic [63:0] val, logic [31:0] cid, int el);
        return (lk <= cnt) && (lk >= cnt - ctx) && ctl[0] && (ctl[23:20] == 4'd3)
               && (el <= 1) && (cid == val[31:0]);
    endfunction

    task automatic chk(bit got, bit exp, string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b link=%0d cnt=%0d ctx=%0d ctrl=%h el=%0d",
                     req, got, exp, link_num, bkpt_cnt_m1, ctx_cnt_m1, bkpt_ctrl, cur_el);
        end
    endtask

    task automatic apply(int lk, int cnt, int ctx, logic [31:0] ctl, logic [63:0] val,
                         logic [31:0] cid, int el, string req);
        bit exp;
        @(negedge clk);
        link_num = 4'(lk); bkpt_cnt_m1 = 4'(cnt); ctx_cnt_m1 = 4'(ctx);
        bkpt_ctrl = ctl; bkpt_value = val; cur_ctxid = cid; cur_el = 2'(el);
        exp = model(lk, cnt, ctx, ctl, val, cid, el);
        #1;
        chk(match_comb, exp, req);
        @(posedge clk);
        #1;
        chk(match_reg, exp, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] cid;
        // R8: registered output held low during reset even with a matching vector
        link_num = 4'd15; bkpt_cnt_m1 = 4'd15; ctx_cnt_m1 = 4'd0;
        bkpt_ctrl = 32'h0030_0001; bkpt_value = 64'h0000_0000_1234_5678;
        cur_ctxid = 32'h1234_5678; cur_el = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        chk(match_reg, 1'b0, "R8");
        chk(match_comb, 1'b1, "R8");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R7: every legal window
        for (int cnt = 0; cnt < 16; cnt++) begin
            for (int ctx = 0; ctx <= cnt; ctx++) begin
                for (int lk = 0; lk < 16; lk++) begin
                    cid = 32'hA5C3_0000 + 32'(cnt * 256 + ctx * 16 + lk);
                    apply(lk, cnt, ctx, 32'h0030_0001, {32'h0, cid}, cid, lk % 2,
                          (ctx == cnt) ? "R7" : ((lk > cnt) ? "R1" : "R2"));
                end
            end
        end

        // R3 R4 R5: type codes x enable x exception level
        for (int t = 0; t < 16; t++) begin
            for (int en = 0; en < 2; en++) begin
                for (int el = 0; el < 4; el++) begin
                    apply(14, 15, 3, {8'h5A, 4'(t), 19'h0, 1'(en)},
                          64'h0000_0000_0BAD_F00D, 32'h0BAD_F00D, el,
                          (el > 1) ? "R5" : ((en == 0) ? "R3" : "R4"));
                end
            end
        end

        // R6: every bit of the identifier counts, upper value bits do not
        for (int b = 0; b < 32; b++) begin
            apply(7, 7, 0, 32'h0030_0001, 64'h0000_0000_CAFE_1234,
                  32'hCAFE_1234 ^ (32'h1 << b), 0, "R6");
            apply(7, 7, 0, 32'h0030_0001, {32'h1 << b, 32'hCAFE_1234},
                  32'hCAFE_1234, 1, "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule